// File: doc/BRIEF.md
# Double-Buffered PWM Generator

This block drives a pulse-width-modulated output from a free-running period counter of `CNT_W` bits (16 by default). The counter advances only on cycles where the tick strobe from an external prescaler is high. Software writes a period value and a pulse-width value into primary registers through three write strobes. One strobe writes the period, one writes the width, and one combined strobe writes both from a double-width data word. The comparison logic never reads the primary copies. It uses secondary copies, and these are refreshed from the primaries only when a period ends, so the output cannot glitch in the middle of a period.

The block covers both limit cases. A width of zero gives a steady low output. A width at or above a nonzero period gives a steady high output. In both cases the counter keeps running, and the output enters or leaves the limit only at a period boundary. A period value of zero selects the longest period, 2^CNT_W ticks.

A combined write that arrives in the same cycle as the period end is handled specially. The refresh at that boundary is skipped, so the old working values govern one more full period.

Top module: `pwm_dbuf`

## Requirements
- R1: After reset, the counter reads 0, the output is low, and the primary and secondary period and width values are all zero.
- R2: The counter advances by exactly one on a cycle with `tick_i` high and holds its value on a cycle with `tick_i` low.
- R3: `wr_per_i` loads `wdata_i[CNT_W-1:0]` into the primary period, and `wr_wid_i` loads the same bits into the primary width. A write made inside a period leaves the output and the counter unchanged until the next period end.
- R4: A period ends on a tick at which the counter equals P-1, where P is the working period (or 2^CNT_W when the working period is 0). At that edge the counter returns to 0 and the secondaries take the primary values.
- R5: From each period start, the output is high for exactly W ticks and low for the rest of the period, where W is the working width. In other terms, the output is high while the counter is below W.
- R6: A width of 1 gives a high pulse exactly one tick long in every period.
- R7: A width of 0 keeps the output low through every period boundary while the counter keeps counting.
- R8: A width equal to or above a nonzero period keeps the output high through every period boundary while the counter keeps counting.
- R9: A period value of 0 gives a 2^CNT_W-tick period. With a width of all ones, the output is high for 2^CNT_W-1 ticks and low for one tick.
- R10: `wr_both_i` loads `wdata_i[2*CNT_W-1:CNT_W]` into the primary period and `wdata_i[CNT_W-1:0]` into the primary width. It takes priority over the single strobes in the same cycle. Made inside a period, it has no effect until the next period end.
- R11: A `wr_both_i` write in the same cycle as a period-end tick suppresses the refresh at that boundary. The previous working values run one more full period, and the new values take effect at the following boundary.
- R12: A single-register write in the same cycle as a period-end tick does not suppress the refresh. The secondaries take the primary values held before that cycle, and the newly written value takes effect at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | PWM clock enable from the prescaler |
| wr_per_i | input | 1 | Write strobe for the primary period |
| wr_wid_i | input | 1 | Write strobe for the primary width |
| wr_both_i | input | 1 | Combined write strobe for period and width |
| wdata_i | input | 2*CNT_W | Write data: period in the upper half for combined writes, low half otherwise |
| cnt_o | output | CNT_W | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The assertions assume that every input is a defined 0 or 1 at each clock edge. They also assume that the working values change only at a period end, so that the width comparison sees one fixed width for the whole period. The bench changes all inputs on the falling edge and holds each write strobe for exactly one cycle. It places boundary-coincident writes by tracking its own model of the counter, so that a write lands on the period-end tick. Tick gaps are inserted only as whole idle cycles.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned PWM_CNT_W_DEF = 16;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_PER  = 2'd1,
    WR_WID  = 2'd2,
    WR_BOTH = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_CNT_W_DEF,
  localparam int unsigned DW = 2 * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_per_i,
  input  logic             wr_wid_i,
  input  logic             wr_both_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             end_i,
  output logic [CNT_W-1:0] sec_per_o,
  output logic [CNT_W-1:0] sec_wid_o,
  output logic [CNT_W-1:0] nxt_wid_o
);
  logic [CNT_W-1:0] pri_per_q, pri_wid_q, sec_per_q, sec_wid_q;
  logic             xfer;
  wr_kind_e         kind;

  always_comb begin
    if (wr_both_i)     kind = WR_BOTH;
    else if (wr_per_i) kind = WR_PER;
    else if (wr_wid_i) kind = WR_WID;
    else               kind = WR_NONE;
  end

  // combined write on the period end defers the refresh one period
  assign xfer = end_i && !wr_both_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pri_per_q <= '0;
      pri_wid_q <= '0;
    end else begin
      unique case (kind)
        WR_BOTH: begin
          pri_per_q <= wdata_i[DW-1:CNT_W];
          pri_wid_q <= wdata_i[CNT_W-1:0];
        end
        WR_PER:  pri_per_q <= wdata_i[CNT_W-1:0];
        WR_WID:  pri_wid_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_per_q <= '0;
      sec_wid_q <= '0;
    end else if (xfer) begin
      sec_per_q <= pri_per_q;
      sec_wid_q <= pri_wid_q;
    end
  end

  assign sec_per_o = sec_per_q;
  assign sec_wid_o = sec_wid_q;
  assign nxt_wid_o = xfer ? pri_wid_q : sec_wid_q;

  AST_SEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_i |=> $stable(sec_per_q) && $stable(sec_wid_q)); // R3
  AST_XFER_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && wr_both_i |=> $stable(sec_per_q) && $stable(sec_wid_q)); // R11
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             end_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, last;

  // period 0 wraps to all ones: 2^CNT_W ticks
  assign last  = per_i - ONE;
  assign end_o = tick_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R2
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> cnt_q == '0); // R4
endmodule

// File: rtl/pwm_outff.sv
module pwm_outff
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] wid_i,
  input  logic [CNT_W-1:0] nxt_wid_i,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic pwm_q;

  // set at period start unless width is zero; first match clears, later ones are moot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                pwm_q <= 1'b0;
    else if (end_i)                             pwm_q <= (nxt_wid_i != '0);
    else if (tick_i && (cnt_i + ONE == wid_i))  pwm_q <= 1'b0;
  end

  assign pwm_o = pwm_q;

  AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(end_i)); // R5
endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W = PWM_CNT_W_DEF,
  localparam int unsigned DW = 2 * CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_per_i,
  input  logic             wr_wid_i,
  input  logic             wr_both_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] sec_per, sec_wid, nxt_wid, cnt;
  logic             per_end;

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_per_i  (wr_per_i),
    .wr_wid_i  (wr_wid_i),
    .wr_both_i (wr_both_i),
    .wdata_i   (wdata_i),
    .end_i     (per_end),
    .sec_per_o (sec_per),
    .sec_wid_o (sec_wid),
    .nxt_wid_o (nxt_wid)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .per_i  (sec_per),
    .cnt_o  (cnt),
    .end_o  (per_end)
  );

  pwm_outff #(.CNT_W(CNT_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .end_i     (per_end),
    .cnt_i     (cnt),
    .wid_i     (sec_wid),
    .nxt_wid_i (nxt_wid),
    .pwm_o     (pwm_o)
  );

  assign cnt_o = cnt;

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wid == '0 |-> !pwm_o); // R7
  AST_FULL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_per != '0) && (sec_wid >= sec_per) |-> pwm_o); // R8
endmodule

// File: tb/pwm_dbuf_test.sv
module pwm_dbuf_test;
  localparam int W          = 8;
  localparam int FULL       = 1 << W;
  localparam int CLK_PERIOD = 10;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           tick_i = 1'b0;
  logic           wr_per_i = 1'b0, wr_wid_i = 1'b0, wr_both_i = 1'b0;
  logic [2*W-1:0] wdata_i = '0;
  logic [W-1:0]   cnt_o;
  logic           pwm_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int m_cnt = 0, m_pper = 0, m_pwid = 0, m_sper = 0, m_swid = 0;

  logic  exp_q[$];
  int    expc_q[$];
  string tag_q[$];

  pwm_dbuf #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .wr_per_i(wr_per_i), .wr_wid_i(wr_wid_i), .wr_both_i(wr_both_i),
    .wdata_i(wdata_i), .cnt_o(cnt_o), .pwm_o(pwm_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int plen();
    return (m_sper == 0) ? FULL : m_sper;
  endfunction

  task automatic step(input logic t, input logic wp, input logic ww, input logic wb,
                      input int d, input string tag);
    @(negedge clk);
    tick_i = t; wr_per_i = wp; wr_wid_i = ww; wr_both_i = wb;
    wdata_i = d[2*W-1:0];
    if (t) begin
      if (m_cnt + 1 == plen()) begin
        m_cnt = 0;
        if (!wb) begin m_sper = m_pper; m_swid = m_pwid; end
      end else m_cnt++;
    end
    if (wb) begin
      m_pper = (d >> W) & (FULL - 1);
      m_pwid = d & (FULL - 1);
    end else begin
      if (wp) m_pper = d & (FULL - 1);
      if (ww) m_pwid = d & (FULL - 1);
    end
    exp_q.push_back(m_cnt < m_swid);
    expc_q.push_back(m_cnt);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  // advance so that the next tick is the period end
  task automatic to_end(input string tag);
    while (m_cnt + 1 != plen()) step(1'b1, 1'b0, 1'b0, 1'b0, 0, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic  e;
      int    c;
      string t;
      e = exp_q.pop_front();
      c = expc_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pwm_o !== e || cnt_o !== c[W-1:0]) begin
        errors++;
        $display("FAIL %s: pwm_o=%0b cnt_o=%0d expected pwm_o=%0b cnt_o=%0d",
                 t, pwm_o, cnt_o, e, c);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3);
    checks++;
    if (pwm_o !== 1'b0 || cnt_o !== '0) begin
      errors++;
      $display("FAIL R1: pwm_o=%0b cnt_o=%0d expected 0 0", pwm_o, cnt_o);
    end
    @(negedge clk); rst_ni = 1'b1;

    // R1: reset values give a full-length period at 0%
    idle(20, "R1 reset period");
    // R3: separate writes inside the first period
    step(1'b1, 1'b1, 1'b0, 1'b0, 10, "R3 write period");
    step(1'b1, 1'b0, 1'b1, 1'b0, 3, "R3 write width");
    idle(30, "R3 no effect before boundary");
    // R2: tick gaps hold the counter
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 0, "R2 hold without tick");
    to_end("R1 run to end");
    step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R4 boundary load");
    idle(25, "R5 width 3 of 10");
    for (int i = 0; i < 12; i++) step(i[0], 1'b0, 1'b0, 1'b0, 0, "R2 alternate ticks");

    step(1'b1, 1'b0, 1'b1, 1'b0, 1, "R6 write width 1");
    to_end("R6 run to end"); idle(25, "R6 one tick pulse");

    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R7 write width 0");
    to_end("R7 run to end"); idle(25, "R7 steady low");

    step(1'b1, 1'b0, 1'b1, 1'b0, 10, "R8 write width equal");
    to_end("R8 run to end"); idle(25, "R8 steady high equal");
    step(1'b1, 1'b0, 1'b1, 1'b0, 200, "R8 write width above");
    to_end("R8 run to end"); idle(25, "R8 steady high above");
    step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R8 leave full");
    to_end("R8 run to end"); idle(12, "R8 leave at boundary");

    step(1'b1, 1'b0, 1'b0, 1'b1, (0 << W) | (FULL - 1), "R9 write period 0");
    to_end("R9 run to end"); idle(2 * FULL + 5, "R9 longest period");

    // R10: combined write beats the single strobe in the same cycle
    step(1'b1, 1'b1, 1'b0, 1'b1, (6 << W) | 2, "R10 combined mid period");
    idle(10, "R10 no effect before boundary");
    to_end("R10 run to end"); idle(20, "R10 period 6 width 2");

    // R11: combined write on the period end
    to_end("R11 run to end");
    step(1'b1, 1'b0, 1'b0, 1'b1, (12 << W) | 5, "R11 combined on boundary");
    idle(40, "R11 deferred transfer");

    // R12: single write on the period end
    to_end("R12 run to end");
    step(1'b1, 1'b0, 1'b1, 1'b0, 9, "R12 width on boundary");
    idle(30, "R12 old primary then new");

    step(1'b0, 1'b0, 1'b0, 1'b0, 0, "R2 final idle");
    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule